// File: doc/BRIEF.md
# Floating-point exception status accumulator

This block keeps the exception half of a floating-point status and control word. Each cycle an arithmetic unit may present a vector of exception events together with an update strobe. The block folds those events into sticky flags. It keeps an invalid-operation summary and a sticky "something happened" bit, and it rebuilds an enabled-exception summary that drives a trap request.

Software reaches the word through a single write port. A write loads the flags and the five enable bits. It is also the only way to clear a sticky flag. A write does not evaluate the enables itself. The next update strobe does that, even when its event vector is empty, so a strobe with no events re-arms the trap after software changes the enables.

Word layout (bit: meaning): 0 any-exception, 1 enabled-exception summary, 2 invalid summary, 3 overflow, 4 underflow, 5 divide-by-zero, 6 inexact, 7..15 invalid causes (7 signaling NaN, 8 inf-inf, 9 inf/inf, 10 0/0, 11 inf*0, 12 invalid compare, 13 software request, 14 square root of negative, 15 invalid integer convert), 16..20 enables for invalid, overflow, underflow, divide-by-zero, inexact, 21..31 reserved and always zero.

Event vector (bit: meaning): 0 overflow, 1 underflow, 2 divide-by-zero, 3 inexact, 4 invalid (general), 5..13 the nine invalid causes in the same order as word bits 7..15.

Top module: `fp_status_acc`

## Requirements
- R1: While the synchronous reset is high at a clock edge, the status word and the trap request become zero.
- R2: An update whose event vector is nonzero sets word bit 0; an update with an all-zero vector leaves bit 0 as it was.
- R3: Event bits 0..3 (overflow, underflow, divide-by-zero, inexact) set word bits 3..6 respectively on an update.
- R4: Event bits 5..13 (invalid causes) set word bits 7..15 respectively on an update.
- R5: After an update, word bit 2 is 1 if it was already 1, if event bit 4 was given, or if any of word bits 7..15 is 1 in the updated word. An update never clears bit 2.
- R6: No update clears any of word bits 0 and 2..15. With neither update nor write, the word does not change.
- R7: On every update, word bit 1 is recomputed to 1 exactly when some flag/enable pair among (bit 2, bit 16), (3, 17), (4, 18), (5, 19), (6, 20) has both bits 1 in the updated word; otherwise it becomes 0.
- R8: The trap request output always equals word bit 1.
- R9: An update with an all-zero event vector still recomputes bits 1 and 2 from the stored flags and enables.
- R10: A write loads bits 0 and 2..20 from the write data, forces bit 1 and bits 21..31 to 0, and takes priority over an update strobe in the same cycle, whose events are then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_i | input | 1 | Update strobe for the event vector |
| ev_i | input | 14 | Exception event vector |
| wr_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| status_o | output | 32 | Status word |
| trap_o | output | 1 | Trap request |

## Verification
The whole state is the status word, and it is visible at the ports on the cycle after each edge. A wrong flag, summary or enable therefore appears at status_o one cycle after the update or write that caused it. A stale trap summary shows on trap_o at the same time. The bench compares the full word and the trap every cycle against a model. It also drives sequences in which a write changes the enables and a later empty update must re-arm the trap. That catches errors which show only through the recompute rule.

// File: rtl/fp_status_acc.sv
module fp_status_acc #(
  parameter int NCAUSE = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd_i,
  input  logic [NCAUSE+4:0]    ev_i,
  input  logic                 wr_i,
  input  logic [31:0]          wr_data_i,
  output logic [31:0]          status_o,
  output logic                 trap_o
);
  localparam int B_ANY  = 0;
  localparam int B_TRAP = 1;
  localparam int B_INV  = 2;
  localparam int B_FLG  = 3;
  localparam int B_CZ   = 7;
  localparam int B_EN   = B_CZ + NCAUSE;
  localparam int TOP    = B_EN + 4;
  localparam logic [31:0] WMASK = ((32'd1 << (TOP + 1)) - 32'd1) & ~(32'd1 << B_TRAP);

  logic [31:0] word_q;
  logic [31:0] merged;

  always_comb begin
    merged = word_q;
    merged[B_ANY] = word_q[B_ANY] | (|ev_i);
    merged[B_FLG +: 4] = word_q[B_FLG +: 4] | ev_i[3:0];
    merged[B_CZ +: NCAUSE] = word_q[B_CZ +: NCAUSE] | ev_i[5 +: NCAUSE];
    merged[B_INV] = word_q[B_INV] | ev_i[4] | (|merged[B_CZ +: NCAUSE]);
    merged[B_TRAP] = |(merged[B_INV +: 5] & merged[B_EN +: 5]);
  end

  always_ff @(posedge clk) begin
    if (rst)        word_q <= '0;
    else if (wr_i)  word_q <= wr_data_i & WMASK;
    else if (upd_i) word_q <= merged;
  end

  assign status_o = word_q;
  assign trap_o   = word_q[B_TRAP];
endmodule

module fp_status_acc_chk (
  input logic        clk,
  input logic        rst,
  input logic        upd_i,
  input logic [13:0] ev_i,
  input logic        wr_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] status_o,
  input logic        trap_o
);
  localparam logic [31:0] STICKY = 32'h0000_FFFD;

  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> (status_o == 32'd0 && !trap_o));
  assert_any_set_R2: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !wr_i && (|ev_i)) |=> status_o[0]);
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !wr_i) |=> ((status_o[6:3] & $past(ev_i[3:0])) == $past(ev_i[3:0])));
  assert_cause_set_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !wr_i) |=> ((status_o[15:7] & $past(ev_i[13:5])) == $past(ev_i[13:5])));
  assert_inv_summary_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !wr_i) |=> (status_o[2] == ($past(status_o[2]) | $past(ev_i[4]) | (|status_o[15:7]))));
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !wr_i) |=> ((($past(status_o) & STICKY) & ~status_o) == 32'd0));
  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (!upd_i && !wr_i) |=> $stable(status_o));
  assert_trap_recompute_R7: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !wr_i) |=> (status_o[1] == (|(status_o[6:2] & status_o[20:16]))));
  assert_trap_matches_R8: assert property (@(posedge clk) disable iff (rst) trap_o == status_o[1]);
  assert_write_load_R10: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (status_o == ($past(wr_data_i) & 32'h001F_FFFD)));
endmodule

bind fp_status_acc fp_status_acc_chk u_chk (
  .clk(clk), .rst(rst), .upd_i(upd_i), .ev_i(ev_i), .wr_i(wr_i),
  .wr_data_i(wr_data_i), .status_o(status_o), .trap_o(trap_o)
);

// File: tb/fp_status_acc_bench.sv
`timescale 1ns/1ps
module fp_status_acc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_i = 1'b0;
  logic [13:0] ev_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] status_o;
  logic        trap_o;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_w = '0;

  always #10 clk = ~clk;

  fp_status_acc u_fp_status_acc (
    .clk(clk), .rst(rst), .upd_i(upd_i), .ev_i(ev_i), .wr_i(wr_i),
    .wr_data_i(wr_data_i), .status_o(status_o), .trap_o(trap_o)
  );

  function automatic logic [31:0] model(input logic [31:0] cur, input logic up,
                                        input logic [13:0] ev, input logic wr,
                                        input logic [31:0] wd);
    logic [31:0] n;
    if (wr) return wd & 32'h001F_FFFD;
    if (!up) return cur;
    n = cur;
    if (ev != 14'd0) n[0] = 1'b1;
    for (int i = 0; i < 4; i++) if (ev[i]) n[3+i] = 1'b1;
    for (int i = 0; i < 9; i++) if (ev[5+i]) n[7+i] = 1'b1;
    if (ev[4] || n[15:7] != 9'd0) n[2] = 1'b1;
    n[1] = (n[2] & n[16]) | (n[3] & n[17]) | (n[4] & n[18]) | (n[5] & n[19]) | (n[6] & n[20]);
    return n;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic up, input logic [13:0] ev,
                     input logic wr, input logic [31:0] wd);
    @(negedge clk);
    upd_i = up; ev_i = ev; wr_i = wr; wr_data_i = wd;
    @(posedge clk);
    exp_w = model(exp_w, up, ev, wr, wd);
    @(negedge clk);
    upd_i = 1'b0; ev_i = '0; wr_i = 1'b0; wr_data_i = '0;
    check(tag, status_o, exp_w);
    check("R8 trap", {31'd0, trap_o}, {31'd0, exp_w[1]});
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    check("R1 reset word", status_o, 32'd0);
    check("R1 reset trap", {31'd0, trap_o}, 32'd0);
    rst = 1'b0;
    exp_w = '0;

    cyc("R2 empty update keeps any clear", 1'b1, 14'd0, 1'b0, 32'd0);
    cyc("R2 R3 overflow event", 1'b1, 14'h0001, 1'b0, 32'd0);
    cyc("R3 inexact event", 1'b1, 14'h0008, 1'b0, 32'd0);
    cyc("R10 write flag and enable", 1'b0, 14'd0, 1'b1, 32'h0002_0008);
    cyc("R9 empty update raises trap", 1'b1, 14'd0, 1'b0, 32'd0);
    cyc("R10 write beats update", 1'b1, 14'h3FFF, 1'b1, 32'h0000_0080);
    cyc("R9 R5 empty update sets invalid summary", 1'b1, 14'd0, 1'b0, 32'd0);
    cyc("R4 sqrt cause", 1'b1, 14'h1000, 1'b0, 32'd0);
    cyc("R10 reserved and trap bits forced low", 1'b0, 14'd0, 1'b1, 32'hFFFF_FFFF);
    cyc("R7 update sets trap", 1'b1, 14'd0, 1'b0, 32'd0);
    cyc("R10 write invalid summary only", 1'b0, 14'd0, 1'b1, 32'h0000_0004);
    cyc("R7 R5 no enable pair keeps trap low", 1'b1, 14'h0004, 1'b0, 32'd0);
    cyc("R6 idle hold", 1'b0, 14'd0, 1'b0, 32'd0);
    cyc("R5 general invalid event", 1'b1, 14'h0010, 1'b0, 32'd0);

    for (int k = 0; k < 3000; k++) begin
      logic up, wr;
      logic [13:0] ev;
      logic [31:0] wd;
      up = ($urandom % 3) != 0;
      wr = ($urandom % 8) == 0;
      ev = ($urandom % 2) ? 14'd0 : (14'd1 << ($urandom % 14));
      if (($urandom % 4) == 0) ev = ev | 14'($urandom);
      wd = $urandom;
      if ($urandom % 2) wd = wd & 32'hFFE0_FFFF;
      cyc("R2 R3 R4 R5 R6 R7 R10 random", up, ev, wr, wd);
      if (($urandom % 200) == 0) begin
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        exp_w = '0;
        check("R1 mid reset", status_o, 32'd0);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule